// File: doc/BRIEF.md
# Locked Accelerator Control Register Window

This block is the control and status register bank of a CPU accelerator, mapped as an eight-byte I/O window on a simple synchronous bus. The window is closed after reset. While it is closed, the shared addresses keep their normal system meaning, and the block answers every read with zero. Software opens the window with a run of unlock key writes and closes it again with a lock key.

While the window is open, software can do the following:

- set the speed step;
- set the option flags and the per-slot and speaker delay enables;
- enable or disable the accelerator;
- mark the next reset as cold;
- read status assembled from live inputs.

Two tag locations return the last captured cache tag. Each read of them has a side effect:

- Reading the clearing location drops the tag-updated flag.
- Reading the arming location requests a trash tag for the next tag write.

The cache, the clock switching and the tag capture are outside the block. They appear only as ports.

There are two resets. `por_n` is an asynchronous power-on reset and always loads the defaults. `wrst_n` is a synchronous warm reset. It keeps the register contents unless the cold flag has been set. The configuration is exported continuously on dedicated outputs.

Top module: `accel_reg_window`

## Requirements
- R1: After power-on reset the window is locked (`unlocked_o`=0), the accelerator is enabled, the speed is 0 (full speed), and all option and delay outputs are 0.
- R2: Four consecutive writes to offset 2 whose upper nibble is 0x5 unlock the window. `unlocked_o` rises after the clock edge of the fourth write.
- R3: Any bus access other than such a key write resets the unlock count to zero. A read or a different write between key writes therefore requires four fresh key writes.
- R4: While locked, every read returns 0x00 with no side effect, and writes to offsets 0, 1, 3, 4 and 5 are ignored. Writes to offset 2 other than the unlock key are also ignored.
- R5: While unlocked, a write to offset 2 with upper nibble 0xA locks the window.
- R6: While unlocked, a write to offset 2 with any other upper nibble (not 0x5, not 0xA) disables the accelerator. Any write to offset 3 enables it again, and the speed setting is kept.
- R7: Offset 1 reads {opt[4:0], warm, dma_i, gs_i}. The top five bits are writable: bit7 language-card cache disable, bit6 paddle delay, bit5 external delay, bit4 counter delay, bit3 follow. They appear on `opt_o[4:0]` in that order. Bits 2..0 are read-only.
- R8: A write to offset 5 sets the speed to wdata[7:4]. Offset 2 reads {speed, 4'hF}.
- R9: Offset 3 reads {ms_clk_i, tag-updated, language-card cache disable, board disabled, slow_dly_i, 0, cache_size_i[1:0]}.
- R10: Offset 4 is read/write. Bits 7..1 drive `slot_dly_o[6:0]` (slots 7..1) and bit 0 drives `spkr_dly_o`. Offset 5 reads `cpu_bank_i`.
- R11: A pulse on `tag_wr_i` sets the tag-updated flag. A read of offset 7 returns `tag_data_i` and clears the flag.
- R12: A read of offset 6 returns `tag_data_i` and sets `trash_arm_o`. The next `tag_wr_i` pulse clears `trash_arm_o`.
- R13: A warm reset with the cold flag clear keeps speed, options, delays and enable, sets the warm bit (offset 1 bit 2), and relocks the window.
- R14: Any write to offset 0 while unlocked sets the cold flag. The next warm reset then loads the defaults of R1 and clears the warm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wrst_n | input | 1 | Synchronous warm reset, active low |
| bus_sel | input | 1 | Window selected this cycle |
| bus_wr | input | 1 | Write strobe (takes priority over read) |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ms_clk_i | input | 1 | 1 ms clock, reported in status |
| slow_dly_i | input | 1 | Slow delay currently in effect |
| cache_size_i | input | 2 | Cache size code (00=8k, 01=16k, 10=32k, 11=64k) |
| dma_i | input | 1 | Hardware DMA present |
| gs_i | input | 1 | Platform identity bit |
| cpu_bank_i | input | 8 | Current CPU bank |
| tag_data_i | input | 8 | Last captured cache tag |
| tag_wr_i | input | 1 | Tag capture pulse |
| unlocked_o | output | 1 | Window open (annunciators overridden) |
| accel_en_o | output | 1 | Accelerator enabled |
| speed_o | output | 4 | Speed step, 0 = full speed |
| opt_o | output | 5 | Option flags (lc-cache disable, paddle, external, counter, follow) |
| slot_dly_o | output | 7 | Slot 7..1 delay enables |
| spkr_dly_o | output | 1 | Speaker delay enable |
| trash_arm_o | output | 1 | Next tag write must store a trash tag |

## Verification
Every register that a write changes drives its output port. The new value appears after the same rising edge that samples the write strobe, so it is due one cycle after the stimulus. Read data is registered too, and is valid after the edge that samples the read strobe. Read side effects such as flag clearing and trash arming take effect on that same edge. The bench drives every strobe on a falling edge and releases it on the next falling edge. It samples outputs at that release point, which is exactly half a cycle after the edge that was due to change them.

// File: rtl/accel_win_pkg.sv
package accel_win_pkg;

    typedef logic [2:0] ofs_t;

    localparam ofs_t OFS_COLD  = 3'd0;
    localparam ofs_t OFS_OPT   = 3'd1;
    localparam ofs_t OFS_KEY   = 3'd2;
    localparam ofs_t OFS_STAT  = 3'd3;
    localparam ofs_t OFS_SLOT  = 3'd4;
    localparam ofs_t OFS_SPEED = 3'd5;
    localparam ofs_t OFS_TAGA  = 3'd6;
    localparam ofs_t OFS_TAGC  = 3'd7;

    localparam int SPEED_W = 4;
    localparam int OPT_W   = 5;
    localparam int SLOT_W  = 7;

    typedef struct packed {
        logic [SPEED_W-1:0] speed;
        logic [OPT_W-1:0]   opt;
        logic [SLOT_W-1:0]  slot_dly;
        logic               spkr_dly;
        logic               en;
        logic               cold;
        logic               warm;
        logic               tag_upd;
        logic               trash;
    } cfg_t;

    function automatic cfg_t cfg_defaults();
        cfg_t c;
        c    = '0;
        c.en = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/accel_unlock_seq.sv
module accel_unlock_seq #(
    parameter int         UNLOCK_WRITES = 4,
    parameter logic [3:0] KEY_UNLOCK    = 4'h5,
    parameter logic [3:0] KEY_LOCK      = 4'hA
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       wrst_n,
    input  logic       acc_i,
    input  logic       key_wr_i,
    input  logic [3:0] key_i,
    output logic       unlocked_o
);
    localparam int CNT_W = $clog2(UNLOCK_WRITES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UNLOCK_WRITES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             unlocked;
    } seq_t;

    seq_t seq_d, seq_q;
    logic unlock_hit, lock_hit;

    always_comb begin
        unlock_hit = key_wr_i && (key_i == KEY_UNLOCK);
        lock_hit   = key_wr_i && (key_i == KEY_LOCK) && seq_q.unlocked;
        seq_d      = seq_q;
        if (!wrst_n) begin
            seq_d = '0;
        end else if (unlock_hit) begin
            if (seq_q.unlocked) begin
                seq_d.cnt = '0;
            end else if (seq_q.cnt == LAST) begin
                seq_d.unlocked = 1'b1;
                seq_d.cnt      = '0;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end else if (lock_hit) begin
            seq_d.unlocked = 1'b0;
            seq_d.cnt      = '0;
        end else if (acc_i) begin
            seq_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign unlocked_o = seq_q.unlocked;

    // R2
    unlock_needs_key_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(seq_q.unlocked) |-> $past(unlock_hit && wrst_n));

    // R3
    count_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
        (acc_i && !unlock_hit) |=> (seq_q.cnt == '0));

    // R5
    lock_key_chk: assert property (@(posedge clk) disable iff (!por_n)
        (key_wr_i && key_i == KEY_LOCK) |=> !seq_q.unlocked);

endmodule

// File: rtl/accel_cfg_regs.sv
module accel_cfg_regs
    import accel_win_pkg::*;
#(
    parameter logic [3:0] KEY_UNLOCK = 4'h5,
    parameter logic [3:0] KEY_LOCK   = 4'hA
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       wrst_n,
    input  logic       wr_i,
    input  logic       rd_i,
    input  ofs_t       ofs_i,
    input  logic [7:0] wdata_i,
    input  logic       unlocked_i,
    input  logic       tag_wr_i,
    output cfg_t       cfg_o
);
    cfg_t cfg_d, cfg_q, kept;
    logic wr_ok, rd_ok;

    always_comb begin
        wr_ok = wr_i && unlocked_i;
        rd_ok = rd_i && unlocked_i;
        cfg_d = cfg_q;
        if (wr_ok) begin
            case (ofs_i)
                OFS_COLD:  cfg_d.cold = 1'b1;
                OFS_OPT:   cfg_d.opt  = wdata_i[7:3];
                OFS_KEY: begin
                    if (wdata_i[7:4] != KEY_UNLOCK && wdata_i[7:4] != KEY_LOCK)
                        cfg_d.en = 1'b0;
                end
                OFS_STAT:  cfg_d.en = 1'b1;
                OFS_SLOT:  {cfg_d.slot_dly, cfg_d.spkr_dly} = wdata_i;
                OFS_SPEED: cfg_d.speed = wdata_i[7:4];
                default:   ;
            endcase
        end
        if (rd_ok && ofs_i == OFS_TAGC) cfg_d.tag_upd = 1'b0;
        if (rd_ok && ofs_i == OFS_TAGA) cfg_d.trash   = 1'b1;
        if (tag_wr_i) begin
            cfg_d.tag_upd = 1'b1;
            cfg_d.trash   = 1'b0;
        end
        kept         = cfg_q;
        kept.warm    = 1'b1;
        kept.tag_upd = 1'b0;
        kept.trash   = 1'b0;
        if (!wrst_n) cfg_d = cfg_q.cold ? cfg_defaults() : kept;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cfg_q <= cfg_defaults();
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R4
    locked_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!unlocked_i && !tag_wr_i && wrst_n) |=> $stable(cfg_q));

    // R8
    speed_src_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(cfg_q.speed) |->
            ($past(wr_i && unlocked_i && ofs_i == OFS_SPEED) || $past(!wrst_n)));

    // R11
    tag_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rd_i && unlocked_i && ofs_i == OFS_TAGC && !tag_wr_i && wrst_n) |=> !cfg_q.tag_upd);

    // R14
    cold_reload_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!wrst_n && cfg_q.cold) |=> (cfg_q.speed == '0 && cfg_q.en && !cfg_q.cold && !cfg_q.warm));

endmodule

// File: rtl/accel_rd_mux.sv
module accel_rd_mux
    import accel_win_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic               rd_i,
    input  ofs_t               ofs_i,
    input  logic               unlocked_i,
    input  logic [SPEED_W-1:0] speed_i,
    input  logic [OPT_W-1:0]   opt_i,
    input  logic [SLOT_W-1:0]  slot_i,
    input  logic               spkr_i,
    input  logic               en_i,
    input  logic               warm_i,
    input  logic               tag_upd_i,
    input  logic               ms_clk_i,
    input  logic               slow_dly_i,
    input  logic [1:0]         cache_size_i,
    input  logic               dma_i,
    input  logic               gs_i,
    input  logic [7:0]         bank_i,
    input  logic [7:0]         tag_data_i,
    output logic [7:0]         rdata_o
);
    logic [7:0] rdata_d, rdata_q, sel_val;

    always_comb begin
        case (ofs_i)
            OFS_OPT:   sel_val = {opt_i, warm_i, dma_i, gs_i};
            OFS_KEY:   sel_val = {speed_i, 4'hF};
            OFS_STAT:  sel_val = {ms_clk_i, tag_upd_i, opt_i[OPT_W-1], !en_i,
                                  slow_dly_i, 1'b0, cache_size_i};
            OFS_SLOT:  sel_val = {slot_i, spkr_i};
            OFS_SPEED: sel_val = bank_i;
            OFS_TAGA,
            OFS_TAGC:  sel_val = tag_data_i;
            default:   sel_val = 8'h00;
        endcase
        rdata_d = rdata_q;
        if (rd_i) rdata_d = unlocked_i ? sel_val : 8'h00;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

    // R4
    locked_read_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rd_i && !unlocked_i) |=> (rdata_o == 8'h00));

    // R10
    bank_read_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rd_i && unlocked_i && ofs_i == OFS_SPEED) |=> (rdata_o == $past(bank_i)));

endmodule

// File: rtl/accel_reg_window.sv
module accel_reg_window
    import accel_win_pkg::*;
#(
    parameter int         UNLOCK_WRITES = 4,
    parameter logic [3:0] KEY_UNLOCK    = 4'h5,
    parameter logic [3:0] KEY_LOCK      = 4'hA
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       wrst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ms_clk_i,
    input  logic       slow_dly_i,
    input  logic [1:0] cache_size_i,
    input  logic       dma_i,
    input  logic       gs_i,
    input  logic [7:0] cpu_bank_i,
    input  logic [7:0] tag_data_i,
    input  logic       tag_wr_i,
    output logic       unlocked_o,
    output logic       accel_en_o,
    output logic [3:0] speed_o,
    output logic [4:0] opt_o,
    output logic [6:0] slot_dly_o,
    output logic       spkr_dly_o,
    output logic       trash_arm_o
);
    logic acc, wr_en, rd_en, key_wr, unlocked;
    cfg_t cfg;

    always_comb begin
        acc    = bus_sel && (bus_wr || bus_rd);
        wr_en  = bus_sel && bus_wr;
        rd_en  = bus_sel && bus_rd && !bus_wr;
        key_wr = wr_en && (bus_addr == OFS_KEY);
    end

    accel_unlock_seq #(
        .UNLOCK_WRITES(UNLOCK_WRITES),
        .KEY_UNLOCK   (KEY_UNLOCK),
        .KEY_LOCK     (KEY_LOCK)
    ) i_seq (
        .clk       (clk),
        .por_n     (por_n),
        .wrst_n    (wrst_n),
        .acc_i     (acc),
        .key_wr_i  (key_wr),
        .key_i     (bus_wdata[7:4]),
        .unlocked_o(unlocked)
    );

    accel_cfg_regs #(
        .KEY_UNLOCK(KEY_UNLOCK),
        .KEY_LOCK  (KEY_LOCK)
    ) i_cfg (
        .clk       (clk),
        .por_n     (por_n),
        .wrst_n    (wrst_n),
        .wr_i      (wr_en),
        .rd_i      (rd_en),
        .ofs_i     (bus_addr),
        .wdata_i   (bus_wdata),
        .unlocked_i(unlocked),
        .tag_wr_i  (tag_wr_i),
        .cfg_o     (cfg)
    );

    accel_rd_mux i_rd (
        .clk         (clk),
        .por_n       (por_n),
        .rd_i        (rd_en),
        .ofs_i       (bus_addr),
        .unlocked_i  (unlocked),
        .speed_i     (cfg.speed),
        .opt_i       (cfg.opt),
        .slot_i      (cfg.slot_dly),
        .spkr_i      (cfg.spkr_dly),
        .en_i        (cfg.en),
        .warm_i      (cfg.warm),
        .tag_upd_i   (cfg.tag_upd),
        .ms_clk_i    (ms_clk_i),
        .slow_dly_i  (slow_dly_i),
        .cache_size_i(cache_size_i),
        .dma_i       (dma_i),
        .gs_i        (gs_i),
        .bank_i      (cpu_bank_i),
        .tag_data_i  (tag_data_i),
        .rdata_o     (bus_rdata)
    );

    assign unlocked_o  = unlocked;
    assign accel_en_o  = cfg.en;
    assign speed_o     = cfg.speed;
    assign opt_o       = cfg.opt;
    assign slot_dly_o  = cfg.slot_dly;
    assign spkr_dly_o  = cfg.spkr_dly;
    assign trash_arm_o = cfg.trash;

    // R6
    enable_write_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && unlocked && bus_addr == OFS_STAT && wrst_n && !tag_wr_i) |=> accel_en_o);

    // R12
    trash_arm_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rd_en && unlocked && bus_addr == OFS_TAGA && wrst_n && !tag_wr_i) |=> trash_arm_o);

endmodule

// File: tb/test_accel_reg_window.sv
module test_accel_reg_window;
    logic       clk = 1'b0;
    logic       por_n = 1'b0, wrst_n = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ms_clk_i = 1'b0, slow_dly_i = 1'b0, dma_i = 1'b0, gs_i = 1'b0, tag_wr_i = 1'b0;
    logic [1:0] cache_size_i = 2'b01;
    logic [7:0] cpu_bank_i = 8'h00, tag_data_i = 8'h00;
    logic       unlocked_o, accel_en_o, spkr_dly_o, trash_arm_o;
    logic [3:0] speed_o;
    logic [4:0] opt_o;
    logic [6:0] slot_dly_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rd_val;

    always #10 clk = ~clk;

    accel_reg_window i_accel_reg_window (
        .clk(clk), .por_n(por_n), .wrst_n(wrst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ms_clk_i(ms_clk_i), .slow_dly_i(slow_dly_i), .cache_size_i(cache_size_i),
        .dma_i(dma_i), .gs_i(gs_i), .cpu_bank_i(cpu_bank_i),
        .tag_data_i(tag_data_i), .tag_wr_i(tag_wr_i),
        .unlocked_o(unlocked_o), .accel_en_o(accel_en_o), .speed_o(speed_o),
        .opt_o(opt_o), .slot_dly_o(slot_dly_o), .spkr_dly_o(spkr_dly_o),
        .trash_arm_o(trash_arm_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
        rd_val = bus_rdata;
    endtask

    task automatic tag_pulse();
        @(negedge clk); tag_wr_i = 1'b1;
        @(negedge clk); tag_wr_i = 1'b0;
    endtask

    task automatic warm_reset();
        @(negedge clk); wrst_n = 1'b0;
        @(negedge clk); wrst_n = 1'b1;
    endtask

    task automatic unlock();
        for (int i = 0; i < 4; i++) bus_write(3'd2, 8'h50 | 8'(i));
    endtask

    task automatic t_reset();
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        chk("R1 unlocked", unlocked_o, 0);
        chk("R1 enable", accel_en_o, 1);
        chk("R1 speed", speed_o, 0);
        chk("R1 opt", opt_o, 0);
        chk("R1 slots", {slot_dly_o, spkr_dly_o}, 0);
        bus_read(3'd2);
        chk("R4 locked read", rd_val, 8'h00);
    endtask

    task automatic t_locked_ignore();
        tag_pulse();
        bus_write(3'd5, 8'h70);
        bus_write(3'd1, 8'hF8);
        bus_write(3'd4, 8'hFF);
        bus_write(3'd2, 8'h30);
        chk("R4 speed ignored", speed_o, 0);
        chk("R4 opt ignored", opt_o, 0);
        chk("R4 slots ignored", {slot_dly_o, spkr_dly_o}, 0);
        chk("R4 disable ignored", accel_en_o, 1);
        bus_read(3'd7);
        chk("R4 locked tag read", rd_val, 8'h00);
        for (int i = 0; i < 3; i++) bus_write(3'd2, 8'h55);
        chk("R2 three keys", unlocked_o, 0);
        bus_write(3'd2, 8'h5A);
        chk("R2 fourth key", unlocked_o, 1);
        bus_read(3'd3);
        chk("R4 flag kept / R9 status", rd_val, 8'h41);
    endtask

    task automatic t_regs();
        dma_i = 1'b1; gs_i = 1'b0;
        bus_write(3'd5, 8'hA3);
        chk("R8 speed out", speed_o, 4'hA);
        bus_read(3'd2);
        chk("R8 speed read", rd_val, 8'hAF);
        bus_write(3'd1, 8'hFF);
        chk("R7 opt out", opt_o, 5'h1F);
        bus_read(3'd1);
        chk("R7 opt read", rd_val, 8'hFA);
        bus_write(3'd4, 8'h81);
        chk("R10 slot out", {slot_dly_o, spkr_dly_o}, 8'h81);
        bus_read(3'd4);
        chk("R10 slot read", rd_val, 8'h81);
        cpu_bank_i = 8'h3C;
        bus_read(3'd5);
        chk("R10 bank read", rd_val, 8'h3C);
    endtask

    task automatic t_status();
        ms_clk_i = 1'b1; slow_dly_i = 1'b1; cache_size_i = 2'b10;
        bus_read(3'd3);
        chk("R9 status", rd_val, 8'hEA);
        bus_write(3'd2, 8'h30);
        chk("R6 disable", accel_en_o, 0);
        bus_read(3'd3);
        chk("R9 board disabled", rd_val, 8'hFA);
        bus_write(3'd3, 8'h00);
        chk("R6 enable", accel_en_o, 1);
        chk("R6 speed kept", speed_o, 4'hA);
    endtask

    task automatic t_tag();
        tag_data_i = 8'h99;
        bus_read(3'd7);
        chk("R11 tag read", rd_val, 8'h99);
        bus_read(3'd3);
        chk("R11 flag cleared", rd_val, 8'hAA);
        tag_pulse();
        bus_read(3'd3);
        chk("R11 flag set", rd_val, 8'hEA);
        tag_data_i = 8'h5C;
        bus_read(3'd6);
        chk("R12 tag read", rd_val, 8'h5C);
        chk("R12 armed", trash_arm_o, 1);
        tag_pulse();
        chk("R12 disarmed", trash_arm_o, 0);
    endtask

    task automatic t_lock();
        bus_write(3'd2, 8'hA7);
        chk("R5 locked", unlocked_o, 0);
        bus_read(3'd1);
        chk("R5 read after lock", rd_val, 8'h00);
    endtask

    task automatic t_unlock_break();
        for (int i = 0; i < 3; i++) bus_write(3'd2, 8'h50);
        bus_read(3'd3);
        for (int i = 0; i < 3; i++) bus_write(3'd2, 8'h5F);
        chk("R3 interrupted", unlocked_o, 0);
        bus_write(3'd2, 8'h5F);
        chk("R3 fresh run", unlocked_o, 1);
    endtask

    task automatic t_warm();
        warm_reset();
        chk("R13 relocked", unlocked_o, 0);
        chk("R13 speed kept", speed_o, 4'hA);
        chk("R13 opt kept", opt_o, 5'h1F);
        unlock();
        bus_read(3'd1);
        chk("R13 warm bit", rd_val, 8'hFE);
    endtask

    task automatic t_cold();
        bus_write(3'd0, 8'h00);
        chk("R14 no change yet", speed_o, 4'hA);
        warm_reset();
        chk("R14 speed default", speed_o, 0);
        chk("R14 opt default", opt_o, 0);
        chk("R14 slots default", {slot_dly_o, spkr_dly_o}, 0);
        chk("R14 enable default", accel_en_o, 1);
        unlock();
        bus_read(3'd1);
        chk("R14 warm bit clear", rd_val, 8'h02);
    endtask

    initial begin
        t_reset();
        t_locked_ignore();
        t_regs();
        t_status();
        t_tag();
        t_lock();
        t_unlock_break();
        t_warm();
        t_cold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule